// File: doc/BRIEF.md
# Bus Address Map Register File

This block converts 18-bit device bus addresses, as issued by DMA masters, into 22-bit physical memory addresses. The 18-bit bus space is cut into 32 pages of 8 KB. Each page except the top one has a map entry that holds a 22-bit physical base. The page offset is added to that base. The top page always goes to the fixed I/O page at physical 017760000 (octal), whatever the map holds.

Software sees each 22-bit map entry as a pair of 16-bit registers on a small register port, which accepts word and byte writes. A global map-enable input picks the mode. When it is high, addresses go through the map. When it is low, the trimmed 18-bit bus address is passed on unchanged, zero-extended to 22 bits. The result of each translation request is captured in a register that holds the last translated address.

Top module: `busmap_top`

## Requirements
- R1: While `rst` is high at a clock edge, every map entry is cleared to zero and `xlat_pa` is cleared to zero.
- R2: `reg_addr[6:2]` selects the entry. With `reg_addr[1]`=0, `reg_rdata` returns entry bits 15:0, and bit 0 always reads zero. With `reg_addr[1]`=1, `reg_rdata[5:0]` returns entry bits 21:16 and `reg_rdata[15:6]` read zero. `reg_addr[0]` has no effect on reads. The read path is combinational.
- R3: A word write (`reg_we`=1, `reg_byte`=0) replaces the half selected by `reg_addr[1]` (0 = bits 15:0, 1 = bits 21:16 taken from `reg_wdata[5:0]`). The other half is kept.
- R4: A byte write (`reg_we`=1, `reg_byte`=1) places `reg_wdata[7:0]` into byte lane `reg_addr[1:0]` of a 32-bit view of the entry. Lane 0 is bits 7:0 and lane 3 is bits 31:24. All other bits are kept, so a lane-3 write changes nothing that can be stored.
- R5: After any write, the entry keeps only bits 21:1. Bits above 21 and bit 0 are stored as zero.
- R6: If `xlat_req`=1 and `map_en`=1 at a clock edge, and the page number `xlat_addr[17:13]` is not 31, then after that edge `xlat_pa` = (entry[page] + `xlat_addr[12:0]`) mod 2^22.
- R7: If `xlat_req`=1 and `map_en`=1 and the page number is 31, then after that edge `xlat_pa` = 22'o17760000 + `xlat_addr[12:0]`, whatever the map holds.
- R8: If `xlat_req`=1 and `map_en`=0, then after that edge `xlat_pa` = `xlat_addr[17:0]` zero-extended to 22 bits.
- R9: Bits 21:18 of `xlat_addr` have no effect on any translation.
- R10: `xlat_pa` keeps its value at every edge where `xlat_req`=0.
- R11: If a map write and a translation request fall on the same edge, the translation uses the entry value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_byte | input | 1 | 1 = byte write, 0 = word write |
| reg_addr | input | 7 | Register byte address (entry in bits 6:2) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| map_en | input | 1 | 1 = translate through map, 0 = pass through |
| xlat_req | input | 1 | Translation request strobe |
| xlat_addr | input | 22 | Device bus address (trimmed to 18 bits internally) |
| xlat_pa | output | 22 | Last translated physical address |

## Verification
A register write is committed on the edge where `reg_we` is sampled high. Since the read path is combinational, the bench sets `reg_addr` on a falling edge, lets it settle briefly, and compares `reg_rdata` without waiting for another clock edge. A translation result appears at the one edge that samples `xlat_req`, so the bench raises the request on a falling edge and checks `xlat_pa` at the next falling edge. After that it drops the request and changes the address, and confirms at the following falling edges that the register holds. For the same-edge case, the old entry is expected at the first falling edge after the request and the new entry only after a later request.

// File: rtl/busmap_pkg.sv
package busmap_pkg;

    localparam int BUS_AW   = 18;
    localparam int PA_W     = 22;
    localparam int PAGE_W   = 5;
    localparam int OFF_W    = BUS_AW - PAGE_W;
    localparam int N_PAGES  = 1 << PAGE_W;
    localparam int REG_AW   = PAGE_W + 2;
    localparam int DW       = 16;
    localparam int HI_W     = PA_W - DW;
    localparam int XLAT_IW  = PA_W;

    localparam logic [PA_W-1:0] IO_PAGE_BASE = 22'o17760000;
    localparam logic [PA_W-1:0] ENTRY_MASK   = {{(PA_W-1){1'b1}}, 1'b0};

    typedef logic [PA_W-1:0] paddr_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } busaddr_t;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_WORD = 2'd1,
        WK_BYTE = 2'd2
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e          kind;
        logic [PAGE_W-1:0] idx;
        logic [1:0]        lane;
        logic [DW-1:0]     data;
    } wr_cmd_t;

    // Merge a write into a 32-bit view of an entry, then trim to the storable bits.
    function automatic paddr_t merge_entry(input paddr_t old, input wr_cmd_t cmd);
        logic [31:0] view;
        view = {{(32-PA_W){1'b0}}, old};
        case (cmd.kind)
            WK_WORD: begin
                if (cmd.lane[1]) view[31:16] = cmd.data;
                else             view[15:0]  = cmd.data;
            end
            WK_BYTE: begin
                case (cmd.lane)
                    2'd0: view[7:0]   = cmd.data[7:0];
                    2'd1: view[15:8]  = cmd.data[7:0];
                    2'd2: view[23:16] = cmd.data[7:0];
                    default: view[31:24] = cmd.data[7:0];
                endcase
            end
            default: ;
        endcase
        return view[PA_W-1:0] & ENTRY_MASK;
    endfunction

    // Present one half of an entry on the 16-bit read port.
    function automatic logic [DW-1:0] format_read(input paddr_t ent, input logic hi);
        logic [DW-1:0] r;
        if (hi) r = {{(DW-HI_W){1'b0}}, ent[PA_W-1:DW]};
        else    r = {ent[DW-1:1], 1'b0};
        return r;
    endfunction

endpackage

// File: rtl/busmap_regfile.sv
module busmap_regfile
    import busmap_pkg::*;
#(
    parameter int N_ENT = N_PAGES,
    parameter int IDX_W = PAGE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          wr_cmd,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_hi,
    output logic [DW-1:0]    rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    output paddr_t           lk_entry
);

    paddr_t entries [N_ENT];

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_ent
            logic hit;
            assign hit = (wr_cmd.kind != WK_NONE) && (wr_cmd.idx == IDX_W'(g));
            always_ff @(posedge clk) begin
                if (rst)
                    entries[g] <= '0;
                else if (hit)
                    entries[g] <= merge_entry(entries[g], wr_cmd);
            end
        end
    endgenerate

    always_comb begin
        rd_data  = format_read(entries[rd_idx], rd_hi);
        lk_entry = entries[lk_idx];
    end

endmodule

// File: rtl/busmap_xlate.sv
module busmap_xlate
    import busmap_pkg::*;
(
    input  logic                map_en,
    input  logic [XLAT_IW-1:0]  raw_addr,
    input  paddr_t              entry,
    output logic [PAGE_W-1:0]   page_idx,
    output paddr_t              pa_next
);

    busaddr_t ba;
    logic     last_page;
    paddr_t   off_ext;

    always_comb begin
        ba        = busaddr_t'(raw_addr[BUS_AW-1:0]);
        page_idx  = ba.page;
        last_page = &ba.page;
        off_ext   = PA_W'(ba.off);
        if (!map_en)
            pa_next = PA_W'(raw_addr[BUS_AW-1:0]);
        else if (last_page)
            pa_next = IO_PAGE_BASE + off_ext;
        else
            pa_next = entry + off_ext;
    end

endmodule

// File: rtl/busmap_hold.sv
module busmap_hold
    import busmap_pkg::*;
#(
    parameter int W = PA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/busmap_top.sv
module busmap_top
    import busmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic               reg_byte,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               map_en,
    input  logic               xlat_req,
    input  logic [XLAT_IW-1:0] xlat_addr,
    output logic [PA_W-1:0]    xlat_pa
);

    wr_cmd_t           cmd;
    logic [PAGE_W-1:0] page_idx;
    paddr_t            lk_entry;
    paddr_t            pa_next;

    always_comb begin
        cmd.kind = !reg_we ? WK_NONE : (reg_byte ? WK_BYTE : WK_WORD);
        cmd.idx  = reg_addr[REG_AW-1:2];
        cmd.lane = reg_addr[1:0];
        cmd.data = reg_wdata;
    end

    busmap_regfile #(
        .N_ENT (N_PAGES),
        .IDX_W (PAGE_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_cmd   (cmd),
        .rd_idx   (reg_addr[REG_AW-1:2]),
        .rd_hi    (reg_addr[1]),
        .rd_data  (reg_rdata),
        .lk_idx   (page_idx),
        .lk_entry (lk_entry)
    );

    busmap_xlate u_xlate (
        .map_en   (map_en),
        .raw_addr (xlat_addr),
        .entry    (lk_entry),
        .page_idx (page_idx),
        .pa_next  (pa_next)
    );

    busmap_hold #(
        .W (PA_W)
    ) u_last (
        .clk  (clk),
        .rst  (rst),
        .load (xlat_req),
        .d    (pa_next),
        .q    (xlat_pa)
    );

endmodule

// File: rtl/busmap_chk.sv
module busmap_chk
    import busmap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [DW-1:0]      reg_rdata,
    input logic               map_en,
    input logic               xlat_req,
    input logic [XLAT_IW-1:0] xlat_addr,
    input logic [PA_W-1:0]    xlat_pa
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (xlat_pa == '0));

    assert_hi_word_narrow_R2: assert property (@(posedge clk) disable iff (rst)
        reg_addr[1] |-> (reg_rdata[DW-1:HI_W] == '0));

    assert_lo_bit0_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !reg_addr[1] |-> !reg_rdata[0]);

    assert_io_page_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (xlat_req && map_en && (&xlat_addr[BUS_AW-1:OFF_W]))
        |=> (xlat_pa == IO_PAGE_BASE + PA_W'($past(xlat_addr[OFF_W-1:0]))));

    assert_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
        (xlat_req && !map_en)
        |=> (xlat_pa == PA_W'($past(xlat_addr[BUS_AW-1:0]))));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !xlat_req |=> $stable(xlat_pa));

endmodule

bind busmap_top busmap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .map_en    (map_en),
    .xlat_req  (xlat_req),
    .xlat_addr (xlat_addr),
    .xlat_pa   (xlat_pa)
);

// File: tb/busmap_top_tb.sv
module busmap_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic        reg_byte;
    logic [6:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        map_en;
    logic        xlat_req;
    logic [21:0] xlat_addr;
    logic [21:0] xlat_pa;

    int n_chk = 0;
    int n_bad = 0;
    logic [21:0] model [32];

    always #5 clk = ~clk;

    busmap_top u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_byte(reg_byte),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .map_en(map_en), .xlat_req(xlat_req), .xlat_addr(xlat_addr),
        .xlat_pa(xlat_pa)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [21:0] upd(input logic [21:0] old, input logic [6:0] a,
                                        input logic [15:0] d, input logic bw);
        logic [31:0] v;
        v = {10'd0, old};
        if (bw) v = (v & ~(32'hFF << (8 * a[1:0]))) | ({24'd0, d[7:0]} << (8 * a[1:0]));
        else    v = (v & ~(32'hFFFF << (16 * a[1]))) | ({16'd0, d} << (16 * a[1]));
        return v[21:0] & 22'h3FFFFE;
    endfunction

    function automatic logic [15:0] rd_exp(input logic [6:0] a);
        logic [21:0] m;
        m = model[a[6:2]];
        return a[1] ? {10'd0, m[21:16]} : m[15:0];
    endfunction

    function automatic logic [21:0] xl_exp(input logic [21:0] ad, input logic en);
        logic [17:0] t;
        t = ad[17:0];
        if (!en) return {4'd0, t};
        if (t[17:13] == 5'd31) return 22'o17760000 + {9'd0, t[12:0]};
        return model[t[17:13]] + {9'd0, t[12:0]};
    endfunction

    task automatic wr(input logic [6:0] a, input logic [15:0] d, input logic bw);
        @(negedge clk);
        reg_we = 1'b1; reg_byte = bw; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        model[a[6:2]] = upd(model[a[6:2]], a, d, bw);
    endtask

    task automatic rd(input string tag, input logic [6:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, {16'd0, reg_rdata}, {16'd0, rd_exp(a)});
    endtask

    task automatic xl(input string tag, input logic [21:0] ad, input logic en);
        logic [21:0] e;
        e = xl_exp(ad, en);
        @(negedge clk);
        xlat_req = 1'b1; xlat_addr = ad; map_en = en;
        @(negedge clk);
        xlat_req = 1'b0;
        #1;
        check(tag, {10'd0, xlat_pa}, {10'd0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [21:0] held;
        rst = 1'b1; reg_we = 1'b0; reg_byte = 1'b0; reg_addr = '0; reg_wdata = '0;
        map_en = 1'b0; xlat_req = 1'b0; xlat_addr = '0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of output and all registers (R2 addressing, bit 0 = ignored)
        check("R1 xlat_pa", {10'd0, xlat_pa}, 32'd0);
        for (int a = 0; a < 128; a++) rd("R1 reset read", 7'(a));

        // R3/R5: word writes to every half, hi with junk in bits 15:6, lo with bit 0 set
        for (int i = 0; i < 32; i++) begin
            wr(7'(i * 4), 16'hA5A5 ^ 16'(i * 16'h1357) | 16'h0001, 1'b0);
            wr(7'(i * 4 + 2), 16'hFFC0 | 16'(i * 7 + 3), 1'b0);
        end
        for (int a = 0; a < 128; a++) rd("R2 R3 R5 word readback", 7'(a));

        // R4: byte lanes on entry 9, lane 3 must have no effect
        wr(7'(9 * 4 + 0), 16'h12FF, 1'b1);
        rd("R4 lane0 lo", 7'(9 * 4));
        rd("R4 lane0 hi", 7'(9 * 4 + 2));
        wr(7'(9 * 4 + 1), 16'h34C3, 1'b1);
        rd("R4 lane1 lo", 7'(9 * 4));
        wr(7'(9 * 4 + 2), 16'h56FF, 1'b1);
        rd("R4 R5 lane2 hi", 7'(9 * 4 + 2));
        held = model[9];
        wr(7'(9 * 4 + 3), 16'h78FF, 1'b1);
        rd("R4 lane3 lo", 7'(9 * 4));
        rd("R4 lane3 hi", 7'(9 * 4 + 2));
        check("R4 lane3 model", {10'd0, model[9]}, {10'd0, held});

        // R6/R7/R9: translate every page at three offsets, junk in bits 21:18
        for (int p = 0; p < 32; p++) begin
            xl("R6 R7 R9 off0", {4'hF, 5'(p), 13'h0000}, 1'b1);
            xl("R6 R7 R9 offmax", {4'hA, 5'(p), 13'h1FFF}, 1'b1);
            xl("R6 R7 off mid", {4'h0, 5'(p), 13'(p * 16'h0111)}, 1'b1);
        end

        // R6: modulo 2^22 wrap
        wr(7'(5 * 4), 16'hFFFF, 1'b0);
        wr(7'(5 * 4 + 2), 16'h003F, 1'b0);
        xl("R6 wrap", {4'h0, 5'd5, 13'h1FFF}, 1'b1);
        check("R6 wrap const", {10'd0, xlat_pa}, 32'h0000_1FFD);

        // R7: page 31 ignores its map entry
        wr(7'(31 * 4), 16'h4444, 1'b0);
        xl("R7 last page", {4'h0, 5'd31, 13'h0123}, 1'b1);
        check("R7 last page const", {10'd0, xlat_pa}, 32'h003F_E123);

        // R8/R9: map disabled sweep
        for (int p = 0; p < 32; p++)
            xl("R8 R9 passthrough", {4'h5, 5'(p), 13'(p * 16'h00F3 + 1)}, 1'b0);

        // R10: hold while no request
        xl("R10 setup", {4'h0, 5'd3, 13'h0042}, 1'b1);
        held = xlat_pa;
        @(negedge clk); xlat_addr = 22'h3FFFFF; map_en = 1'b0;
        @(negedge clk); check("R10 hold a", {10'd0, xlat_pa}, {10'd0, held});
        @(negedge clk); map_en = 1'b1; xlat_addr = 22'h012345;
        @(negedge clk); check("R10 hold b", {10'd0, xlat_pa}, {10'd0, held});

        // R11: write and request on the same edge
        held = xl_exp({4'h0, 5'd12, 13'h0010}, 1'b1);
        @(negedge clk);
        reg_we = 1'b1; reg_byte = 1'b0; reg_addr = 7'(12 * 4); reg_wdata = 16'h8000;
        xlat_req = 1'b1; map_en = 1'b1; xlat_addr = {4'h0, 5'd12, 13'h0010};
        @(negedge clk);
        reg_we = 1'b0; xlat_req = 1'b0;
        model[12] = upd(model[12], 7'(12 * 4), 16'h8000, 1'b0);
        #1;
        check("R11 old entry used", {10'd0, xlat_pa}, {10'd0, held});
        xl("R11 new entry next", {4'h0, 5'd12, 13'h0010}, 1'b1);

        // R1: reset again clears the map
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        check("R1 second reset xlat_pa", {10'd0, xlat_pa}, 32'd0);
        rd("R1 second reset lo", 7'(12 * 4));
        rd("R1 second reset hi", 7'(5 * 4 + 2));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule